// File: doc/BRIEF.md
# Decimal Segmented Address Generator

This block turns a decimal operand pointer into a physical digit address. A pointer is eight packed BCD digits: a sign digit, a segment digit and a six-digit offset. The segment digit picks one of eight base/limit register pairs. An operand can also be indexed: it then names one of seven index registers, and its offset is added in decimal to that register's pointer, which supplies the sign and the segment.

The offset that results is checked against the segment's limit. It is then relocated onto a base that is kept in units of 1000 digits, which gives a nine-digit BCD physical address. Illegal digits, signs and segments, a carry out of the indexed offset add, and limit violations each return their own fault code. When a fault is returned, the address is forced to zero.

Software loads the base, limit and index registers through a simple write port. Requests arrive one per cycle, and each result comes back one cycle later with a valid strobe.

Top module: `dec_seg_agen`

## Requirements
- R1: Pointer layout is sign in bits [31:28], segment digit in bits [27:24], and offset digits in bits [23:0], with the least significant digit in [3:0]. The effective sign must be hex C or hex D; any other sign gives fault code 2.
- R2: Fault code 1 is returned when any nibble above 9 appears in the operand's six offset digits or in the effective segment digit. In indexed mode, the same check also covers the index register's six offset digits.
- R3: An effective segment digit of 8 or 9 gives fault code 3.
- R4: Index select 0 uses the operand directly. Values 1 to 7 select an index register. The sign and segment then come from that register, and the operand's own sign and segment digits are ignored.
- R5: In indexed mode, the effective offset is the six-digit decimal sum of the two offsets. A carry out of the top digit gives fault code 4.
- R6: An effective offset greater than the selected segment's limit gives fault code 5. An offset equal to the limit is accepted.
- R7: With no fault, the physical address is base × 1000 + offset, taken modulo 10^9 as nine BCD digits in bits [35:0].
- R8: When only one fault applies, its code is returned. When several apply, the priority from highest to lowest is: code 1, code 2, code 3, code 4, code 5. Code 0 means no fault.
- R9: The result and res_valid appear on the clock edge after req_valid. A faulted result carries an address of zero. With res_valid low, both the fault and the address read zero.
- R10: Write kinds are 0 for base (data [23:0]), 1 for limit (data [23:0]) and 2 for index (data [31:0], wr_num 1 to 7). A write becomes visible to a request presented on the next cycle, not to one presented in the same cycle.
- R11: Reset clears every base, limit and index register, as well as the result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | 0 base, 1 limit, 2 index, 3 no-op |
| wr_num | input | 3 | Segment number or index register number |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Operand pointer |
| req_xsel | input | 3 | Index select, 0 for none |
| res_valid | output | 1 | Result strobe |
| res_paddr | output | 36 | Nine-digit BCD physical address |
| res_fault | output | 3 | Fault code |

## Verification
Every result is produced from register state within a single cycle. A corrupted base, limit or index register therefore shows on the first request that touches it, as a wrong address or a wrong fault code one clock after that request. A broken decimal carry shows up only when the digit sums cross 9. For that reason, the vectors include offsets that ripple a carry through all digits, relocations that wrap past 10^9, and offsets that sit exactly on a limit or one digit above it. A stale or premature register write shows as a result that differs between two back-to-back requests placed around the write.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
    localparam int DIG_W        = 4;
    localparam int PTR_DIGITS   = 8;
    localparam int OFF_DIGITS   = 6;
    localparam int BASE_DIGITS  = 6;
    localparam int ALIGN_DIGITS = 3;
    localparam int SEG_NUM      = 8;
    localparam int IDX_NUM      = 7;
    localparam int PTR_W        = PTR_DIGITS * DIG_W;
    localparam int OFF_W        = OFF_DIGITS * DIG_W;
    localparam int BASE_W       = BASE_DIGITS * DIG_W;
    localparam int PA_W         = (BASE_DIGITS + ALIGN_DIGITS) * DIG_W;
    localparam int NUM_W        = $clog2(SEG_NUM);

    localparam logic [DIG_W-1:0] SIGN_PLUS  = 4'hC;
    localparam logic [DIG_W-1:0] SIGN_MINUS = 4'hD;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_DIGIT  = 3'd1,
        FLT_SIGN   = 3'd2,
        FLT_SEG    = 3'd3,
        FLT_OVF    = 3'd4,
        FLT_BOUNDS = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        WK_BASE  = 2'd0,
        WK_LIMIT = 2'd1,
        WK_INDEX = 2'd2,
        WK_NONE  = 2'd3
    } wkind_e;
endpackage

// File: rtl/dsa_bcd_add.sv
module dsa_bcd_add #(
    parameter int NDIG = 6
) (
    input  logic [NDIG*4-1:0] a,
    input  logic [NDIG*4-1:0] b,
    input  logic              cin,
    output logic [NDIG*4-1:0] sum,
    output logic              cout
);
    logic [NDIG:0] carry;
    assign carry[0] = cin;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        logic [4:0] raw;
        logic [4:0] adj;
        always_comb begin
            raw = {1'b0, a[g*4 +: 4]} + {1'b0, b[g*4 +: 4]} + {4'd0, carry[g]};
            adj = (raw > 5'd9) ? raw + 5'd6 : raw;
        end
        assign sum[g*4 +: 4] = adj[3:0];
        assign carry[g+1]    = (raw > 5'd9);
    end

    assign cout = carry[NDIG];
endmodule

// File: rtl/dsa_digit_chk.sv
module dsa_digit_chk #(
    parameter int NDIG = 6
) (
    input  logic [NDIG*4-1:0] val,
    output logic              bad
);
    logic [NDIG-1:0] nib_bad;
    for (genvar g = 0; g < NDIG; g++) begin : g_nib
        assign nib_bad[g] = (val[g*4 +: 4] > 4'd9);
    end
    assign bad = |nib_bad;
endmodule

// File: rtl/dsa_regfile.sv
module dsa_regfile
    import dsa_pkg::*;
#(
    parameter int SEGS  = SEG_NUM,
    parameter int IDXS  = IDX_NUM,
    parameter int BW    = BASE_W,
    parameter int LW    = OFF_W,
    parameter int PW    = PTR_W,
    parameter int NW    = NUM_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_kind,
    input  logic [NW-1:0]            wr_num,
    input  logic [PW-1:0]            wr_data,
    output logic [SEGS-1:0][BW-1:0]  base_o,
    output logic [SEGS-1:0][LW-1:0]  limit_o,
    output logic [IDXS-1:0][PW-1:0]  index_o
);
    typedef struct packed {
        logic [SEGS-1:0][BW-1:0] base;
        logic [SEGS-1:0][LW-1:0] limit;
        logic [IDXS-1:0][PW-1:0] index;
    } rf_t;

    rf_t rf_d, rf_q;
    logic [NW-1:0] xslot;

    always_comb begin
        rf_d  = rf_q;
        xslot = wr_num - 1'b1;
        if (wr_en) begin
            case (wkind_e'(wr_kind))
                WK_BASE:  rf_d.base[wr_num]  = wr_data[BW-1:0];
                WK_LIMIT: rf_d.limit[wr_num] = wr_data[LW-1:0];
                WK_INDEX: begin
                    if (wr_num != '0 && int'(wr_num) <= IDXS)
                        rf_d.index[xslot] = wr_data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign base_o  = rf_q.base;
    assign limit_o = rf_q.limit;
    assign index_o = rf_q.index;
endmodule

// File: rtl/dec_seg_agen.sv
module dec_seg_agen
    import dsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [NUM_W-1:0]  wr_num,
    input  logic [PTR_W-1:0]  wr_data,
    input  logic              req_valid,
    input  logic [PTR_W-1:0]  req_addr,
    input  logic [NUM_W-1:0]  req_xsel,
    output logic              res_valid,
    output logic [PA_W-1:0]   res_paddr,
    output logic [2:0]        res_fault
);
    localparam int ALIGN_W = ALIGN_DIGITS * DIG_W;
    localparam int HI_W    = OFF_W - ALIGN_W;

    typedef struct packed {
        logic            valid;
        fault_e          fault;
        logic [PA_W-1:0] paddr;
    } res_t;

    logic [SEG_NUM-1:0][BASE_W-1:0] base_v;
    logic [SEG_NUM-1:0][OFF_W-1:0]  limit_v;
    logic [IDX_NUM-1:0][PTR_W-1:0]  index_v;

    dsa_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_kind (wr_kind),
        .wr_num  (wr_num),
        .wr_data (wr_data),
        .base_o  (base_v),
        .limit_o (limit_v),
        .index_o (index_v)
    );

    logic               indexed;
    logic [NUM_W-1:0]   xslot;
    logic [PTR_W-1:0]   xptr;
    logic [DIG_W-1:0]   eff_sign, eff_seg;
    logic [OFF_W-1:0]   add_b, eff_off;
    logic               off_carry;
    logic               op_bad, x_bad;
    logic [NUM_W-1:0]   seg_sel;
    logic [BASE_W-1:0]  reloc_hi;
    logic               reloc_carry;

    always_comb begin
        indexed  = (req_xsel != '0);
        xslot    = req_xsel - 1'b1;
        xptr     = indexed ? index_v[xslot] : '0;
        eff_sign = indexed ? xptr[PTR_W-1 -: DIG_W] : req_addr[PTR_W-1 -: DIG_W];
        eff_seg  = indexed ? xptr[OFF_W +: DIG_W]   : req_addr[OFF_W +: DIG_W];
        add_b    = xptr[OFF_W-1:0];
        seg_sel  = eff_seg[NUM_W-1:0];
    end

    dsa_bcd_add #(.NDIG(OFF_DIGITS)) u_offadd (
        .a    (req_addr[OFF_W-1:0]),
        .b    (add_b),
        .cin  (1'b0),
        .sum  (eff_off),
        .cout (off_carry)
    );

    dsa_digit_chk #(.NDIG(OFF_DIGITS + 1)) u_opchk (
        .val ({eff_seg, req_addr[OFF_W-1:0]}),
        .bad (op_bad)
    );

    dsa_digit_chk #(.NDIG(OFF_DIGITS)) u_xchk (
        .val (add_b),
        .bad (x_bad)
    );

    dsa_bcd_add #(.NDIG(BASE_DIGITS)) u_reloc (
        .a    (base_v[seg_sel]),
        .b    ({{(BASE_W-HI_W){1'b0}}, eff_off[OFF_W-1:ALIGN_W]}),
        .cin  (1'b0),
        .sum  (reloc_hi),
        .cout (reloc_carry)
    );

    res_t res_d, res_q;

    always_comb begin
        res_d       = '0;
        res_d.valid = req_valid;
        if (req_valid) begin
            if (op_bad || (indexed && x_bad))
                res_d.fault = FLT_DIGIT;
            else if (eff_sign != SIGN_PLUS && eff_sign != SIGN_MINUS)
                res_d.fault = FLT_SIGN;
            else if (eff_seg >= DIG_W'(SEG_NUM))
                res_d.fault = FLT_SEG;
            else if (indexed && off_carry)
                res_d.fault = FLT_OVF;
            else if (eff_off > limit_v[seg_sel])
                res_d.fault = FLT_BOUNDS;
            else
                res_d.paddr = {reloc_hi, eff_off[ALIGN_W-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign res_paddr = res_q.paddr;
    assign res_fault = res_q.fault;

    logic unused_ok;
    assign unused_ok = reloc_carry;
endmodule

// File: rtl/dsa_chk.sv
module dsa_chk
    import dsa_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [PTR_W-1:0]  req_addr,
    input logic [NUM_W-1:0]  req_xsel,
    input logic              res_valid,
    input logic [PA_W-1:0]   res_paddr,
    input logic [2:0]        res_fault
);
    function automatic logic nibbles_ok(input logic [27:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < 7; i++) if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    logic direct, sign_good, digs_good;
    assign direct    = req_valid && (req_xsel == '0);
    assign sign_good = (req_addr[31:28] == SIGN_PLUS) || (req_addr[31:28] == SIGN_MINUS);
    assign digs_good = nibbles_ok(req_addr[27:0]);

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_fault == 3'd0 && res_paddr == '0));

    // R9
    fault_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault != 3'd0) |-> res_paddr == '0);

    // R8
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault <= 3'd5);

    // R1
    bad_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (direct && !sign_good && digs_good && req_addr[27:24] < 4'd8)
        |=> res_fault == 3'd2);

    // R3
    bad_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (direct && sign_good && digs_good && req_addr[27:24] >= 4'd8)
        |=> res_fault == 3'd3);

    // R7
    low_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        direct |=> (res_fault != 3'd0 || res_paddr[11:0] == $past(req_addr[11:0])));
endmodule

bind dec_seg_agen dsa_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_xsel  (req_xsel),
    .res_valid (res_valid),
    .res_paddr (res_paddr),
    .res_fault (res_fault)
);

// File: tb/tb_dec_seg_agen.sv
module tb_dec_seg_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = '0;
    logic [2:0]  wr_num = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_xsel = '0;
    logic        res_valid;
    logic [35:0] res_paddr;
    logic [2:0]  res_fault;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dec_seg_agen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_num(wr_num), .wr_data(wr_data), .req_valid(req_valid),
        .req_addr(req_addr), .req_xsel(req_xsel), .res_valid(res_valid),
        .res_paddr(res_paddr), .res_fault(res_fault)
    );

    // {req tag, xsel, addr, expected fault, expected paddr}
    localparam int NV = 24;
    localparam logic [77:0] VEC [NV] = '{
        {4'd7,  3'd0, 32'hC0000000, 3'd0, 36'h000000000}, // R7
        {4'd7,  3'd0, 32'hC1012345, 3'd0, 36'h000135345}, // R7
        {4'd6,  3'd0, 32'hD1050000, 3'd0, 36'h000173000}, // R6 equal limit
        {4'd6,  3'd0, 32'hC1050001, 3'd5, 36'h000000000}, // R6
        {4'd7,  3'd0, 32'hC2999999, 3'd0, 36'h000998999}, // R7 wrap
        {4'd6,  3'd0, 32'hC3000500, 3'd0, 36'h012345500}, // R6
        {4'd6,  3'd0, 32'hC3000501, 3'd5, 36'h000000000}, // R6
        {4'd1,  3'd0, 32'hB0000000, 3'd2, 36'h000000000}, // R1
        {4'd3,  3'd0, 32'hC8000000, 3'd3, 36'h000000000}, // R3
        {4'd3,  3'd0, 32'hC9000000, 3'd3, 36'h000000000}, // R3
        {4'd2,  3'd0, 32'hC00A0000, 3'd1, 36'h000000000}, // R2
        {4'd2,  3'd0, 32'hCA000000, 3'd1, 36'h000000000}, // R2
        {4'd8,  3'd0, 32'h5812345F, 3'd1, 36'h000000000}, // R8 digit first
        {4'd8,  3'd0, 32'h58000000, 3'd2, 36'h000000000}, // R8 sign over seg
        {4'd4,  3'd1, 32'h00001234, 3'd0, 36'h000124734}, // R4
        {4'd5,  3'd1, 32'h00049500, 3'd0, 36'h000173000}, // R5 carry ripple
        {4'd6,  3'd1, 32'h00049501, 3'd5, 36'h000000000}, // R6 indexed
        {4'd4,  3'd2, 32'h00000100, 3'd0, 36'h012345500}, // R4
        {4'd5,  3'd3, 32'h00000001, 3'd4, 36'h000000000}, // R5 overflow
        {4'd4,  3'd3, 32'h00000000, 3'd0, 36'h000999999}, // R4
        {4'd3,  3'd4, 32'h00000000, 3'd3, 36'h000000000}, // R3 via index
        {4'd1,  3'd5, 32'h00000000, 3'd2, 36'h000000000}, // R1 via index
        {4'd2,  3'd6, 32'h00000000, 3'd1, 36'h000000000}, // R2 index digits
        {4'd7,  3'd0, 32'hD0123456, 3'd0, 36'h000123456}  // R7
    };

    task automatic check(input string tag, input logic v, input logic [2:0] f,
                         input logic [35:0] p, input logic ev,
                         input logic [2:0] ef, input logic [35:0] ep);
        total++;
        if (v !== ev || f !== ef || p !== ep) begin
            bad++;
            $display("FAIL %s: got v=%0b f=%0d p=%h, want v=%0b f=%0d p=%h",
                     tag, v, f, p, ev, ef, ep);
        end
    endtask

    task automatic wr(input logic [1:0] k, input logic [2:0] n, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_num = n; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic req(input logic [2:0] x, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_xsel = x; req_addr = a;
        @(posedge clk); #1;
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset outputs", res_valid, res_fault, res_paddr, 1'b0, 3'd0, '0);
        @(negedge clk); rst_n = 1'b1;

        // R11: registers clear -> base 0, limit 0
        req(3'd0, 32'hC0000000);
        check("R11 zero limit ok", res_valid, res_fault, res_paddr, 1'b1, 3'd0, '0);
        req(3'd0, 32'hC0000001);
        check("R11 zero limit bounds", res_valid, res_fault, res_paddr, 1'b1, 3'd5, '0);
        @(negedge clk); req_valid = 1'b0;
        @(posedge clk); #1;
        check("R9 idle", res_valid, res_fault, res_paddr, 1'b0, 3'd0, '0);

        // R10: load registers
        wr(2'd1, 3'd0, 32'h00999999);
        wr(2'd0, 3'd1, 32'h00000123); wr(2'd1, 3'd1, 32'h00050000);
        wr(2'd0, 3'd2, 32'h00999999); wr(2'd1, 3'd2, 32'h00999999);
        wr(2'd0, 3'd3, 32'h00012345); wr(2'd1, 3'd3, 32'h00000500);
        wr(2'd2, 3'd1, 32'hC1000500);
        wr(2'd2, 3'd2, 32'hD3000400);
        wr(2'd2, 3'd3, 32'hC0999999);
        wr(2'd2, 3'd4, 32'hC8000000);
        wr(2'd2, 3'd5, 32'hA0000000);
        wr(2'd2, 3'd6, 32'hC10A0000);
        wr(2'd3, 3'd1, 32'h00000000); // R10 kind 3 no-op

        for (int i = 0; i < NV; i++) begin
            logic [77:0] v;
            v = VEC[i];
            req(v[73:71], v[70:39]);
            check($sformatf("R%0d vector %0d", v[77:74], i), res_valid, res_fault,
                  res_paddr, 1'b1, v[38:36], v[35:0]);
        end

        // R10: kind 3 write left seg1 base intact
        req(3'd0, 32'hC1000000);
        check("R10 no-op kind", res_valid, res_fault, res_paddr, 1'b1, 3'd0, 36'h000123000);

        // R10: same-cycle write not seen, next cycle seen
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 2'd1; wr_num = 3'd4; wr_data = 32'h00000100;
        req_valid = 1'b1; req_xsel = 3'd0; req_addr = 32'hC4000050;
        @(posedge clk); #1;
        wr_en = 1'b0;
        check("R10 same cycle", res_valid, res_fault, res_paddr, 1'b1, 3'd5, '0);
        @(posedge clk); #1;
        check("R10 next cycle", res_valid, res_fault, res_paddr, 1'b1, 3'd0, 36'h000000050);

        // R9: back to idle clears outputs
        @(negedge clk); req_valid = 1'b0;
        @(posedge clk); #1;
        check("R9 idle after", res_valid, res_fault, res_paddr, 1'b0, 3'd0, '0);

        // R11: reset mid-run clears registers again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        req(3'd0, 32'hC1000001);
        check("R11 limits cleared", res_valid, res_fault, res_paddr, 1'b1, 3'd5, '0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule